// File: doc/BRIEF.md
# AES Inverse Mix-Columns Vector Unit

This unit applies the AES InvMixColumns transform to a 128-bit round key and writes the result into the low 128 bits of a wider vector destination. It is used to turn the expanded round keys of an encryption schedule into keys for the equivalent inverse cipher. Every round key except the first and the last goes through it. The operation raises no floating-point exceptions.

The bits above bit 127 of the destination depend on the encoding mode. In legacy mode they keep the previous destination value. In extended mode they are cleared. Extended mode also checks a 4-bit reserved register-specifier field, which must be all ones. Any other value raises an undefined-instruction fault, and the destination passes through untouched.

Operations enter on a valid/ready input channel and leave on a valid/ready output channel, through a single register stage. A transfer happens on a rising edge where valid and ready are both high. While a finished result is held with `out_ready` low, `in_ready` is low and the held result does not change. When `out_ready` is high, the stage takes a new operation in the same cycle that the held one leaves. The producer may hold `in_valid` high for any number of cycles while `in_ready` is low.

Top module: `aesimc_unit`

## Requirements
- R1: The 128-bit key is taken as four 32-bit columns: column c is bits [32c+31:32c], and byte 0 (the least significant byte) is the first byte of column 0. Output byte r of a column is 0E·a[r] ^ 0B·a[r+1] ^ 0D·a[r+2] ^ 09·a[r+3], with the indices taken mod 4 and the products in GF(2^8) reduced by x^8+x^4+x^3+x+1. This result goes to `out_dst[127:0]`.
- R2: In legacy mode (`in_ext_mode`=0), `out_dst[VLEN-1:128]` equals `in_old_dst[VLEN-1:128]`.
- R3: In extended mode (`in_ext_mode`=1) with `in_rsvd`=4'b1111, `out_dst[VLEN-1:128]` is zero.
- R4: In extended mode with `in_rsvd` other than 4'b1111, `out_fault` is 1 and `out_dst` equals the whole `in_old_dst` unchanged. A result still appears on the output channel.
- R5: In legacy mode, `in_rsvd` has no effect: `out_fault` is 0 and `out_dst` is the same for every value of `in_rsvd`.
- R6: A result appears with `out_valid` high on the first rising edge after the edge that accepted its operation.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_dst` and `out_fault` hold their values.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R9: An active-low synchronous reset (`rst_n`) clears `out_valid`, `out_dst` and `out_fault`.
- R10: An all-zero key yields an all-zero low half. For any 128-bit x, applying the unit to MixColumns(x) returns x in the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_key | input | 128 | Round key source |
| in_old_dst | input | VLEN | Previous destination register value |
| in_ext_mode | input | 1 | 0 = legacy (keep upper bits), 1 = extended (clear upper bits) |
| in_rsvd | input | 4 | Reserved register-specifier field |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_dst | output | VLEN | New destination value |
| out_fault | output | 1 | Undefined-instruction fault for this result |

## Verification
The bench builds the unit with the default VLEN of 256. With that value the destination has a 128-bit upper half, so the bench can observe both keeping the old upper bits and clearing them, and it can see the whole old value pass through on a fault. The configuration where VLEN is 128, which has no upper half, is not built. At 256 bits the mode paths are the only source of any difference in the upper half.

// File: rtl/aesimc_pkg.sv
package aesimc_pkg;
  localparam int BLK_W  = 128;
  localparam int COL_W  = 32;
  localparam int N_COLS = BLK_W / COL_W;
  localparam int N_ROWS = COL_W / 8;
  localparam int RSVD_W = 4;
  localparam logic [RSVD_W-1:0] RSVD_LEGAL = '1;
  localparam logic [7:0] REDUCE_LO = 8'h1B;

  typedef logic [N_ROWS-1:0][7:0] col_t;

  // multiply by x modulo the AES field polynomial
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? REDUCE_LO : 8'h00);
  endfunction

  // multiply by a 4-bit constant through a doubling chain
  function automatic logic [7:0] gf_mulk(input logic [7:0] a, input logic [3:0] k);
    logic [7:0] p1, p2, p4, p8, acc;
    p1  = a;
    p2  = gf_dbl(p1);
    p4  = gf_dbl(p2);
    p8  = gf_dbl(p4);
    acc = 8'h00;
    if (k[0]) acc = acc ^ p1;
    if (k[1]) acc = acc ^ p2;
    if (k[2]) acc = acc ^ p4;
    if (k[3]) acc = acc ^ p8;
    return acc;
  endfunction
endpackage

// File: rtl/aesimc_column.sv
module aesimc_column
  import aesimc_pkg::*;
(
  input  col_t col_in,
  output col_t col_out
);
  localparam logic [3:0] K_E = 4'hE;
  localparam logic [3:0] K_B = 4'hB;
  localparam logic [3:0] K_D = 4'hD;
  localparam logic [3:0] K_9 = 4'h9;

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    localparam int I0 = r;
    localparam int I1 = (r + 1) % N_ROWS;
    localparam int I2 = (r + 2) % N_ROWS;
    localparam int I3 = (r + 3) % N_ROWS;
    assign col_out[r] = gf_mulk(col_in[I0], K_E) ^ gf_mulk(col_in[I1], K_B)
                      ^ gf_mulk(col_in[I2], K_D) ^ gf_mulk(col_in[I3], K_9);
  end
endmodule

// File: rtl/aesimc_merge.sv
module aesimc_merge
  import aesimc_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic [BLK_W-1:0]  mixed,
  input  logic [VLEN-1:0]   old_dst,
  input  logic              ext_mode,
  input  logic [RSVD_W-1:0] rsvd,
  output logic [VLEN-1:0]   new_dst,
  output logic              fault
);
  localparam int UP_W = VLEN - BLK_W;

  assign fault = ext_mode && (rsvd != RSVD_LEGAL);

  if (UP_W > 0) begin : g_wide
    logic [UP_W-1:0] upper;
    assign upper   = ext_mode ? '0 : old_dst[VLEN-1:BLK_W];
    assign new_dst = fault ? old_dst : {upper, mixed};
  end else begin : g_narrow
    assign new_dst = fault ? old_dst : mixed;
  end
endmodule

// File: rtl/aesimc_unit.sv
module aesimc_unit
  import aesimc_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [127:0]      in_key,
  input  logic [VLEN-1:0]   in_old_dst,
  input  logic              in_ext_mode,
  input  logic [3:0]        in_rsvd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VLEN-1:0]   out_dst,
  output logic              out_fault
);
  localparam int UP_W = VLEN - BLK_W;

  logic [BLK_W-1:0] mixed;
  logic [VLEN-1:0]  merged;
  logic             merged_fault;

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    col_t cin, cout;
    assign cin = in_key[c*COL_W +: COL_W];
    aesimc_column u_col (.col_in(cin), .col_out(cout));
    assign mixed[c*COL_W +: COL_W] = cout;
  end

  aesimc_merge #(.VLEN(VLEN)) u_merge (
    .mixed   (mixed),
    .old_dst (in_old_dst),
    .ext_mode(in_ext_mode),
    .rsvd    (in_rsvd),
    .new_dst (merged),
    .fault   (merged_fault)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dst   <= '0;
      out_fault <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_dst   <= merged;
        out_fault <= merged_fault;
      end
    end
  end

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_fault));

  p_fault_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_ext_mode && (in_rsvd != 4'hF)
    |=> out_fault && (out_dst == $past(in_old_dst)));

  p_legacy_nofault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_ext_mode |=> !out_fault);

  if (UP_W > 0) begin : g_up_chk
    p_upper_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_ext_mode
      |=> out_dst[VLEN-1:BLK_W] == $past(in_old_dst[VLEN-1:BLK_W]));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_ext_mode && (in_rsvd == 4'hF)
      |=> out_dst[VLEN-1:BLK_W] == '0);
  end
endmodule

// File: tb/sim_aesimc_unit.sv
module sim_aesimc_unit;
  localparam int VLEN = 256;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [127:0]     in_key;
  logic [VLEN-1:0]  in_old_dst;
  logic             in_ext_mode;
  logic [3:0]       in_rsvd;
  logic             out_valid;
  logic             out_ready;
  logic [VLEN-1:0]  out_dst;
  logic             out_fault;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aesimc_unit #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_old_dst(in_old_dst), .in_ext_mode(in_ext_mode),
    .in_rsvd(in_rsvd), .out_valid(out_valid), .out_ready(out_ready),
    .out_dst(out_dst), .out_fault(out_fault)
  );

  task automatic check(input bit ok, input string tag, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  // forward MixColumns, byte 0 = LSB = first byte of column 0
  function automatic logic [127:0] fwd_mix(input logic [127:0] x);
    logic [127:0] y;
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a [4];
      for (int r = 0; r < 4; r++) a[r] = x[c*32 + r*8 +: 8];
      for (int r = 0; r < 4; r++)
        y[c*32 + r*8 +: 8] = xt(a[r]) ^ (xt(a[(r+1)%4]) ^ a[(r+1)%4])
                           ^ a[(r+2)%4] ^ a[(r+3)%4];
    end
    return y;
  endfunction

  task automatic issue(input logic [127:0] key, input logic [VLEN-1:0] old,
                       input bit ext, input logic [3:0] rsvd);
    @(negedge clk);
    in_valid = 1'b1; in_key = key; in_old_dst = old; in_ext_mode = ext; in_rsvd = rsvd;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid", {255'd0, out_valid}, '0);
    check(out_dst == '0, "R9 out_dst", out_dst, '0);
    check(out_fault == 1'b0, "R9 out_fault", {255'd0, out_fault}, '0);
    check(in_ready == 1'b1, "R8 ready idle", {255'd0, in_ready}, {255'd0, 1'b1});
  endtask

  task automatic t_known;
    logic [127:0] key, exp;
    logic [VLEN-1:0] old;
    key = {32'h01010101, 32'hc6c6c6c6, 32'h9d58dc9f, 32'hbca14d8e};
    exp = {32'h01010101, 32'hc6c6c6c6, 32'h5c220af2, 32'h455313db};
    old = {128'hA5A5_0000_1111_2222_3333_4444_5555_6666, 128'hDEAD};
    issue(key, old, 1'b0, 4'hF);
    check(out_valid == 1'b1, "R6 valid after one edge", {255'd0, out_valid}, {255'd0, 1'b1});
    check(out_dst[127:0] == exp, "R1 known columns", out_dst, {old[255:128], exp});
    check(out_dst[255:128] == old[255:128], "R2 legacy upper kept", out_dst, {old[255:128], exp});
    check(out_fault == 1'b0, "R5 legacy no fault", {255'd0, out_fault}, '0);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 valid drops", {255'd0, out_valid}, '0);
  endtask

  task automatic t_zero;
    issue('0, {128'hFFFF, 128'h1234}, 1'b1, 4'hF);
    check(out_dst == '0, "R10 zero key and R3 upper zero", out_dst, '0);
  endtask

  task automatic t_ext_clear;
    logic [127:0] x;
    x = 128'h00112233_44556677_8899aabb_ccddeeff;
    issue(fwd_mix(x), {VLEN{1'b1}}, 1'b1, 4'hF);
    check(out_dst == {128'd0, x}, "R3 ext upper cleared", out_dst, {128'd0, x});
    check(out_fault == 1'b0, "R3 ext legal no fault", {255'd0, out_fault}, '0);
  endtask

  task automatic t_fault;
    logic [VLEN-1:0] old;
    old = {64'h0123456789ABCDEF, 64'h1, 64'h2, 64'h3};
    issue(128'hFEEDFACE, old, 1'b1, 4'b0111);
    check(out_fault == 1'b1, "R4 fault raised", {255'd0, out_fault}, {255'd0, 1'b1});
    check(out_dst == old, "R4 old dst passed", out_dst, old);
    check(out_valid == 1'b1, "R4 result still delivered", {255'd0, out_valid}, {255'd0, 1'b1});
    issue(128'hFEEDFACE, old, 1'b1, 4'b1110);
    check(out_fault == 1'b1 && out_dst == old, "R4 fault rsvd 1110", out_dst, old);
  endtask

  task automatic t_legacy_rsvd;
    logic [127:0] x;
    logic [VLEN-1:0] old;
    x = 128'hCAFEBABE_0BADF00D_13579BDF_2468ACE0;
    old = {128'h77, 128'h88};
    for (int v = 0; v < 16; v += 5) begin
      issue(fwd_mix(x), old, 1'b0, v[3:0]);
      check(out_fault == 1'b0 && out_dst == {old[255:128], x}, "R5 legacy rsvd ignored",
            out_dst, {old[255:128], x});
    end
  endtask

  task automatic t_roundtrip;
    for (int i = 0; i < 24; i++) begin
      logic [127:0] x;
      x = {$urandom(), $urandom(), $urandom(), $urandom()};
      issue(fwd_mix(x), {128'd0, ~x}, 1'b0, 4'hF);
      check(out_dst[127:0] == x, "R10 roundtrip", out_dst, {128'd0, x});
    end
  endtask

  task automatic t_backpressure;
    logic [127:0] xa, xb;
    xa = 128'h1;
    xb = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    @(negedge clk);
    out_ready = 1'b0;
    issue(fwd_mix(xa), '0, 1'b1, 4'hF);
    check(in_ready == 1'b0, "R8 ready low when full", {255'd0, in_ready}, '0);
    in_valid = 1'b1; in_key = fwd_mix(xb); in_old_dst = '0; in_ext_mode = 1'b1; in_rsvd = 4'hF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1 && out_dst == {128'd0, xa}, "R7 held result",
            out_dst, {128'd0, xa});
      check(in_ready == 1'b0, "R7 ready stays low", {255'd0, in_ready}, '0);
    end
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R8 ready follows out_ready", {255'd0, in_ready}, {255'd0, 1'b1});
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && out_dst == {128'd0, xb}, "R6 R8 swap in same edge",
          out_dst, {128'd0, xb});
    @(negedge clk);
  endtask

  task automatic t_midreset;
    issue(fwd_mix(128'h55), {VLEN{1'b1}}, 1'b0, 4'hF);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(out_valid == 1'b0 && out_dst == '0 && out_fault == 1'b0, "R9 reset clears",
          out_dst, '0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_key = '0; in_old_dst = '0;
    in_ext_mode = 1'b0; in_rsvd = 4'hF; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_known();
    t_zero();
    t_ext_clear();
    t_fault();
    t_legacy_rsvd();
    t_roundtrip();
    t_backpressure();
    t_midreset();
    done = 1;
    finish_run();
  end
endmodule